// File: doc/BRIEF.md
# Priority Interrupt Controller

This block collects up to eight level-sensitive request lines from peripherals and presents one interrupt request to a processor. Incoming requests are latched, filtered by a per-line mask, and arbitrated either with fixed priorities (line 0 highest, line 7 lowest) or in rotating mode, where a line that has just been serviced drops to the bottom. The winner must also outrank every line currently in service, so an urgent source can preempt a running handler while an equal or weaker one waits.

When the processor acknowledges, the block records the winning line as in service, drops the request, and on the next cycle presents an 8-bit vector made of a programmable base and the line number. Software writes the mask, the mode, the vector base and end-of-service commands through a small write-only register port. For a second controller wired as a slave onto line 2, the block forwards the acknowledge to the slave instead of driving its own vector. Chaining the two this way gives 15 request lines.

The control state machine has three states. **Idle** moves to **Request** when an eligible request exists. **Request** holds the processor request high and moves to **Vector** when `cpu_ack` is sampled high. It stays in **Request** even if the eligible request is withdrawn. **Vector** lasts one cycle, drives either the vector or the cascade acknowledge, and always returns to **Idle**.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `cpu_irq`, `vec_valid` and `casc_ack` are low, every line is masked (mask = 8'hFF), the mode is fixed priority with cascade off, the vector base is 0 and no line is in service.
- R2: A request line that is high at clock edge t sets `cpu_irq` after edge t+1, provided the line is eligible at that edge. When `cpu_ack` is high at an edge in the Request state, `cpu_irq` falls and `vec_valid` is high for exactly the following cycle.
- R3: In fixed mode, among eligible requests the lowest line number wins.
- R4: Register address 0 holds the mask; bit i = 1 blocks line i from being forwarded. A blocked line stays latched and is forwarded once it is unmasked.
- R5: Register address 2 sets the vector base from write data bits [7:3]. The vector is {base[4:0], line[2:0]}.
- R6: Acknowledge places the winning line in service. A request is forwarded only if its priority is strictly higher than every line in service, so a higher line preempts and an equal or lower line waits.
- R7: A write to address 3 ends service. If write data bit 7 = 0, it clears the highest-priority in-service line. If bit 7 = 1, it clears the line given by bits [2:0].
- R8: Register address 1 bit 0 = 1 selects rotating mode. When service of a line is ended, that line becomes the lowest priority and the next line up becomes the highest. With all lines requesting, the service order is 0,1,...,7,0,...
- R9: If no eligible request exists when `cpu_ack` arrives, the vector for line 7 is returned and no line is placed in service.
- R10: With register address 1 bit 1 = 1, acknowledging line 2 pulses `casc_ack` for one cycle in place of `vec_valid`. Other lines are not affected.
- R11: An acknowledge and an end-of-service command in the same cycle both take effect. The command acts on the lines in service before that edge, and the newly acknowledged line stays in service.
- R12: A request pulse is held until it is acknowledged. A line still held high is latched again after its acknowledge and requests again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 8 | Level-sensitive peripheral request lines |
| cpu_irq | output | 1 | Interrupt request to the processor |
| cpu_ack | input | 1 | Processor acknowledge |
| vec_data | output | 8 | Vector byte, valid while vec_valid is high |
| vec_valid | output | 1 | Vector presented this cycle |
| casc_ack | output | 1 | Acknowledge forwarded to a slave controller on line 2 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 mask, 1 mode, 2 base, 3 end-of-service |
| reg_wdata | input | 8 | Register write data |

## Verification
The acknowledge, which sets an in-service bit and clears a request, can land on the same edge as an end-of-service write, which clears an in-service bit and may move the rotation point. The bench provokes this by putting line 4 in service and then acknowledging line 1 while it writes a non-specific end-of-service command. Afterwards line 2 must be blocked, which shows that line 1 is still in service. Once line 1 is cleared, line 5 must be forwarded, which shows that the command removed line 4. Near-exhaustive sweeps cover every pair of simultaneous lines, every mask value, and every base with every line, with the expected winners computed arithmetically.

// File: rtl/pic_pkg.sv
package pic_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_VEC  = 2'd2
    } pic_state_e;

    localparam logic [1:0] ADDR_MASK = 2'd0;
    localparam logic [1:0] ADDR_MODE = 2'd1;
    localparam logic [1:0] ADDR_BASE = 2'd2;
    localparam logic [1:0] ADDR_EOI  = 2'd3;
endpackage

// File: rtl/pic_resolver.sv
// Picks the highest-priority set bit; the priority ring starts just above `lowest`.
module pic_resolver #(
    parameter int N_LINES = 8,
    localparam int IDX_W  = $clog2(N_LINES)
) (
    input  logic [N_LINES-1:0] bits,
    input  logic [IDX_W-1:0]   lowest,
    output logic               any,
    output logic [IDX_W-1:0]   idx,
    output logic [IDX_W-1:0]   rank
);
    logic [IDX_W-1:0] pos;

    always_comb begin
        any  = 1'b0;
        idx  = '0;
        rank = '0;
        pos  = '0;
        for (int k = N_LINES - 1; k >= 0; k--) begin
            pos = lowest + IDX_W'(1) + IDX_W'(k);
            if (bits[pos]) begin
                any  = 1'b1;
                idx  = pos;
                rank = IDX_W'(k);
            end
        end
    end
endmodule

// File: rtl/pic_regs.sv
module pic_regs #(
    parameter int N_LINES = 8,
    parameter int VEC_W   = 8,
    localparam int IDX_W  = $clog2(N_LINES),
    localparam int BASE_W = VEC_W - IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [1:0]         addr,
    input  logic [VEC_W-1:0]   wdata,
    output logic [N_LINES-1:0] mask,
    output logic               rotate,
    output logic               casc_en,
    output logic [BASE_W-1:0]  base,
    output logic               eoi_fire,
    output logic               eoi_specific,
    output logic [IDX_W-1:0]   eoi_line
);
    import pic_pkg::*;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask    <= '1;
            rotate  <= 1'b0;
            casc_en <= 1'b0;
            base    <= '0;
        end else if (we) begin
            unique case (addr)
                ADDR_MASK: mask <= wdata[N_LINES-1:0];
                ADDR_MODE: begin
                    rotate  <= wdata[0];
                    casc_en <= wdata[1];
                end
                ADDR_BASE: base <= wdata[VEC_W-1:IDX_W];
                default: ;
            endcase
        end
    end

    always_comb begin
        eoi_fire     = we && (addr == ADDR_EOI);
        eoi_specific = wdata[VEC_W-1];
        eoi_line     = wdata[IDX_W-1:0];
    end

    p_mask_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_MASK) |=> (mask == $past(wdata[N_LINES-1:0])));
    p_base_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_BASE) |=> (base == $past(wdata[VEC_W-1:IDX_W])));
endmodule

// File: rtl/pic_service.sv
// In-service tracking and the rotation pointer.
module pic_service #(
    parameter int N_LINES = 8,
    localparam int IDX_W  = $clog2(N_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rotate,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             eoi_fire,
    input  logic             eoi_specific,
    input  logic [IDX_W-1:0] eoi_line,
    output logic [IDX_W-1:0] lowest_eff,
    output logic             isr_any,
    output logic [IDX_W-1:0] isr_rank
);
    logic [N_LINES-1:0] isr_q;
    logic [IDX_W-1:0]   ptr_q;
    logic [IDX_W-1:0]   isr_top;
    logic [IDX_W-1:0]   clr_idx;
    logic               clr_hit;
    logic [N_LINES-1:0] clr_mask;
    logic [N_LINES-1:0] set_mask;

    assign lowest_eff = rotate ? ptr_q : IDX_W'(N_LINES - 1);

    pic_resolver #(.N_LINES(N_LINES)) u_isr_res (
        .bits   (isr_q),
        .lowest (lowest_eff),
        .any    (isr_any),
        .idx    (isr_top),
        .rank   (isr_rank)
    );

    always_comb begin
        clr_idx  = eoi_specific ? eoi_line : isr_top;
        clr_hit  = eoi_fire && (eoi_specific ? isr_q[eoi_line] : isr_any);
        clr_mask = clr_hit ? (N_LINES'(1) << clr_idx) : '0;
        set_mask = set_en ? (N_LINES'(1) << set_idx) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q <= '0;
            ptr_q <= IDX_W'(N_LINES - 1);
        end else begin
            isr_q <= (isr_q & ~clr_mask) | set_mask;
            if (clr_hit && rotate) ptr_q <= clr_idx;
        end
    end

    p_ack_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> isr_q[$past(set_idx)]);
    p_eoi_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_fire && eoi_specific && !(set_en && set_idx == eoi_line))
        |=> !isr_q[$past(eoi_line)]);
    p_rotate_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && rotate) |=> (ptr_q == $past(clr_idx)));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int N_LINES   = 8,
    parameter int VEC_W     = 8,
    parameter int CASC_LINE = 2,
    localparam int IDX_W    = $clog2(N_LINES),
    localparam int BASE_W   = VEC_W - IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_lines,
    output logic               cpu_irq,
    input  logic               cpu_ack,
    output logic [VEC_W-1:0]   vec_data,
    output logic               vec_valid,
    output logic               casc_ack,
    input  logic               reg_we,
    input  logic [1:0]         reg_addr,
    input  logic [VEC_W-1:0]   reg_wdata
);
    import pic_pkg::*;

    pic_state_e state_q, state_d;

    logic [N_LINES-1:0] irr_q;
    logic [N_LINES-1:0] mask;
    logic               rotate, casc_en;
    logic [BASE_W-1:0]  base;
    logic               eoi_fire, eoi_specific;
    logic [IDX_W-1:0]   eoi_line;
    logic [IDX_W-1:0]   lowest_eff;
    logic               isr_any;
    logic [IDX_W-1:0]   isr_rank;
    logic               cand_any, cand_ok;
    logic [IDX_W-1:0]   cand_idx, cand_rank;
    logic               ack_take, set_en;
    logic [IDX_W-1:0]   served_q;
    logic               spur_q;
    logic [N_LINES-1:0] ack_clr;

    pic_regs #(.N_LINES(N_LINES), .VEC_W(VEC_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .we           (reg_we),
        .addr         (reg_addr),
        .wdata        (reg_wdata),
        .mask         (mask),
        .rotate       (rotate),
        .casc_en      (casc_en),
        .base         (base),
        .eoi_fire     (eoi_fire),
        .eoi_specific (eoi_specific),
        .eoi_line     (eoi_line)
    );

    pic_resolver #(.N_LINES(N_LINES)) u_req_res (
        .bits   (irr_q & ~mask),
        .lowest (lowest_eff),
        .any    (cand_any),
        .idx    (cand_idx),
        .rank   (cand_rank)
    );

    always_comb begin
        cand_ok  = cand_any && (!isr_any || (cand_rank < isr_rank));
        ack_take = (state_q == ST_REQ) && cpu_ack;
        set_en   = ack_take && cand_ok;
        ack_clr  = set_en ? (N_LINES'(1) << cand_idx) : '0;
    end

    pic_service #(.N_LINES(N_LINES)) u_service (
        .clk          (clk),
        .rst_n        (rst_n),
        .rotate       (rotate),
        .set_en       (set_en),
        .set_idx      (cand_idx),
        .eoi_fire     (eoi_fire),
        .eoi_specific (eoi_specific),
        .eoi_line     (eoi_line),
        .lowest_eff   (lowest_eff),
        .isr_any      (isr_any),
        .isr_rank     (isr_rank)
    );

    // Request latch: a pulse is held until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) irr_q <= '0;
        else        irr_q <= (irr_q | irq_lines) & ~ack_clr;
    end

    // Line captured at acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            served_q <= IDX_W'(N_LINES - 1);
            spur_q   <= 1'b0;
        end else if (ack_take) begin
            served_q <= cand_ok ? cand_idx : IDX_W'(N_LINES - 1);
            spur_q   <= !cand_ok;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cand_ok) state_d = ST_REQ;
            ST_REQ:  if (cpu_ack) state_d = ST_VEC;
            ST_VEC:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        cpu_irq   = 1'b0;
        vec_valid = 1'b0;
        casc_ack  = 1'b0;
        vec_data  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_REQ:  cpu_irq = 1'b1;
            ST_VEC: begin
                if (casc_en && !spur_q && served_q == IDX_W'(CASC_LINE)) begin
                    casc_ack = 1'b1;
                end else begin
                    vec_valid = 1'b1;
                    vec_data  = {base, served_q};
                end
            end
            default: ;
        endcase
    end

    p_irq_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq && cpu_ack) |=> (!cpu_irq && (vec_valid || casc_ack)));
    p_vec_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid || casc_ack) |=> !(vec_valid || casc_ack));
    p_cand_eligible_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cand_ok |-> (irr_q[cand_idx] && !mask[cand_idx]));
    p_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_take && !cand_ok) |=> (vec_valid && vec_data[IDX_W-1:0] == IDX_W'(N_LINES - 1)));
    p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({vec_valid, casc_ack, cpu_irq}) <= 1);
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_lines = '0;
    logic       cpu_ack = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       cpu_irq, vec_valid, casc_ack;
    logic [7:0] vec_data;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    prio_irq_ctrl u_prio_irq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_lines (irq_lines),
        .cpu_irq   (cpu_irq),
        .cpu_ack   (cpu_ack),
        .vec_data  (vec_data),
        .vec_valid (vec_valid),
        .casc_ack  (casc_ack),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        step;
        reg_we = 1'b0;
    endtask

    task automatic ack(output logic [7:0] v, output logic vv, output logic ca);
        cpu_ack = 1'b1;
        step;
        v = vec_data; vv = vec_valid; ca = casc_ack;
        cpu_ack = 1'b0;
    endtask

    task automatic wait_irq(input int lim, output logic got);
        got = cpu_irq;
        for (int n = 0; n < lim && !got; n++) begin
            step;
            got = cpu_irq;
        end
    endtask

    task automatic pulse(input logic [7:0] l);
        irq_lines = l;
        step;
        irq_lines = '0;
    endtask

    task automatic drain;
        logic g, vv, ca;
        logic [7:0] v;
        wr(2'd0, 8'h00);
        repeat (8) wr(2'd3, 8'h00);
        for (int n = 0; n < 16; n++) begin
            wait_irq(4, g);
            if (!g) break;
            ack(v, vv, ca);
            wr(2'd3, 8'h00);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic g, vv, ca;
        logic [7:0] v;
        int lo, hi, exp_line;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step;
        // R1: reset state
        chk(!cpu_irq && !vec_valid && !casc_ack, "R1 outputs idle", {cpu_irq, vec_valid, casc_ack}, 0);
        pulse(8'h01);
        wait_irq(3, g);
        chk(!g, "R1 lines masked after reset", g, 0);
        drain;

        // R2: exact latency
        irq_lines = 8'h08;
        step;
        irq_lines = '0;
        chk(!cpu_irq, "R2 no request one edge after latch", cpu_irq, 0);
        step;
        chk(cpu_irq, "R2 request two edges after line", cpu_irq, 1);
        ack(v, vv, ca);
        chk(vv && !cpu_irq && v == 8'h03, "R2 R5 vector after ack", v, 8'h03);
        step;
        chk(!vec_valid, "R2 vector lasts one cycle", vec_valid, 0);
        wr(2'd3, 8'h00);

        // R3 R6 R12: every pair of simultaneous pulses
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                lo = (a < b) ? a : b;
                hi = (a < b) ? b : a;
                pulse(8'((1 << a) | (1 << b)));
                wait_irq(4, g);
                chk(g, "R12 pulse latched", g, 1);
                ack(v, vv, ca);
                chk(vv && v[2:0] == 3'(lo), "R3 lowest line wins", v[2:0], lo);
                if (a != b) begin
                    step; step;
                    chk(!cpu_irq, "R6 lower line waits while higher in service", cpu_irq, 0);
                    wr(2'd3, 8'h00);
                    wait_irq(4, g);
                    chk(g, "R7 non-specific clear frees lower line", g, 1);
                    ack(v, vv, ca);
                    chk(v[2:0] == 3'(hi), "R3 second line served", v[2:0], hi);
                end
                wr(2'd3, 8'h00);
            end
        end

        // R6: equal waits, higher preempts
        for (int a = 1; a < 8; a++) begin
            pulse(8'(1 << a));
            wait_irq(4, g);
            ack(v, vv, ca);
            pulse(8'(1 << a));
            wait_irq(3, g);
            chk(!g, "R6 equal line not forwarded", g, 0);
            pulse(8'(1 << (a - 1)));
            wait_irq(4, g);
            chk(g, "R6 higher line preempts", g, 1);
            ack(v, vv, ca);
            chk(v[2:0] == 3'(a - 1), "R6 preempting vector", v[2:0], a - 1);
            drain;
        end

        // R7: specific clear
        pulse(8'h40);
        wait_irq(4, g); ack(v, vv, ca);
        pulse(8'h10);
        wait_irq(4, g); ack(v, vv, ca);
        wr(2'd3, 8'h86);
        pulse(8'h20);
        wait_irq(3, g);
        chk(!g, "R7 specific clear left line 4 in service", g, 0);
        wr(2'd3, 8'h84);
        wait_irq(4, g);
        chk(g, "R7 specific clear of line 4", g, 1);
        drain;

        // R5: every base with every line
        for (int bs = 0; bs < 32; bs++) begin
            wr(2'd2, 8'(bs << 3));
            for (int l = 0; l < 8; l++) begin
                pulse(8'(1 << l));
                wait_irq(4, g);
                ack(v, vv, ca);
                chk(vv && v == 8'((bs << 3) | l), "R5 vector format", v, (bs << 3) | l);
                wr(2'd3, 8'h00);
            end
        end
        wr(2'd2, 8'h00);

        // R4: every mask value
        for (int m = 0; m < 256; m++) begin
            wr(2'd0, 8'(m));
            pulse(8'hFF);
            wait_irq(3, g);
            chk(g == (m != 255), "R4 mask gates request", g, m != 255);
            if (g) begin
                exp_line = 0;
                while (m[exp_line]) exp_line++;
                ack(v, vv, ca);
                chk(v[2:0] == 3'(exp_line), "R4 lowest unmasked line", v[2:0], exp_line);
                wr(2'd3, 8'h00);
            end
            drain;
        end

        // R8: rotating order with all lines held high
        wr(2'd1, 8'h01);
        irq_lines = 8'hFF;
        exp_line = 0;
        for (int n = 0; n < 16; n++) begin
            wait_irq(4, g);
            chk(g, "R8 request in rotate", g, 1);
            ack(v, vv, ca);
            chk(v[2:0] == 3'(exp_line), "R8 round-robin order", v[2:0], exp_line);
            wr(2'd3, 8'h00);
            exp_line = (exp_line + 1) % 8;
        end
        irq_lines = '0;
        wr(2'd1, 8'h00);
        drain;

        // R12: held line requests again
        irq_lines = 8'h20;
        wait_irq(4, g); ack(v, vv, ca);
        wr(2'd3, 8'h00);
        wait_irq(4, g);
        chk(g, "R12 held line requests again", g, 1);
        irq_lines = '0;
        drain;

        // R10: cascade
        wr(2'd1, 8'h02);
        pulse(8'h04);
        wait_irq(4, g); ack(v, vv, ca);
        chk(ca && !vv, "R10 cascade ack on line 2", {ca, vv}, 2'b10);
        step;
        chk(!casc_ack, "R10 cascade ack one cycle", casc_ack, 0);
        wr(2'd3, 8'h00);
        pulse(8'h08);
        wait_irq(4, g); ack(v, vv, ca);
        chk(vv && !ca && v[2:0] == 3'd3, "R10 other line normal", {ca, vv}, 2'b01);
        wr(2'd3, 8'h00);
        wr(2'd1, 8'h00);
        pulse(8'h04);
        wait_irq(4, g); ack(v, vv, ca);
        chk(vv && !ca && v[2:0] == 3'd2, "R10 line 2 local when cascade off", {ca, vv}, 2'b01);
        drain;

        // R9: spurious acknowledge
        pulse(8'h40);
        wait_irq(4, g);
        wr(2'd0, 8'hFF);
        ack(v, vv, ca);
        chk(vv && v[2:0] == 3'd7, "R9 spurious vector line 7", v[2:0], 7);
        wr(2'd0, 8'h00);
        wait_irq(4, g);
        ack(v, vv, ca);
        chk(v[2:0] == 3'd6, "R9 masked line kept", v[2:0], 6);
        wr(2'd3, 8'h00);
        pulse(8'h80);
        wait_irq(4, g);
        chk(g, "R9 line 7 not put in service", g, 1);
        drain;

        // R11: acknowledge and end-of-service in one cycle
        pulse(8'h10);
        wait_irq(4, g); ack(v, vv, ca);
        pulse(8'h02);
        wait_irq(4, g);
        reg_we = 1'b1; reg_addr = 2'd3; reg_wdata = 8'h00;
        cpu_ack = 1'b1;
        step;
        v = vec_data;
        reg_we = 1'b0; cpu_ack = 1'b0;
        chk(v[2:0] == 3'd1, "R11 vector during joint cycle", v[2:0], 1);
        pulse(8'h04);
        wait_irq(3, g);
        chk(!g, "R11 acked line stays in service", g, 0);
        wr(2'd3, 8'h00);
        wait_irq(4, g); ack(v, vv, ca);
        chk(v[2:0] == 3'd2, "R11 line 2 after clear", v[2:0], 2);
        wr(2'd3, 8'h00);
        pulse(8'h20);
        wait_irq(4, g);
        chk(g, "R11 older line 4 was cleared", g, 1);
        drain;

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule